// File: doc/BRIEF.md
# Bus-to-Static-Memory Width Adapter

This block connects a 32-bit system bus slave port to a 16-bit external static memory data path. Each bus transfer of 8, 16 or 32 bits becomes one or two fixed-length external accesses. The block drives active-low byte-lane enables, places write data on the 16-bit path, gathers read data back into the 32-bit bus word, and answers with an error for transfers the selected bank cannot take. All logic runs on the system bus clock.

The two address bits at the top select one of four banks. Bank 0 is a NOR-style flash, bank 1 an SRAM-style part, bank 2 a removable-card bank and bank 3 a NAND-style flash. Banks 0 and 3 have no byte select; banks 1 and 2 do. Static inputs give a per-bank enable, an access enable for the NOR bank and a card-present level. Bus data uses natural lanes: the byte at byte offset k of a word sits on bits [8k+7:8k], and a half-word at offset 2 sits on bits [31:16].

A transfer is accepted on a rising clock edge where `req_valid` and `bus_ready` are both high. `bus_ready` then stays low until the completion cycle, where it is high again and `bus_rdata`/`bus_err` are valid. Each external access holds `mem_cs` high for `ACC_CYCLES` cycles, and read data is sampled in the last of them.

Top module: `smem_width_adapter`

## Requirements
- R1: A transfer to a bank whose bit in `bank_en` is 0 ends with an error response, and `mem_cs` stays low for the whole transfer.
- R2: A transfer to bank 0 while `nor_acc_en` is 0 ends with an error response and no external access.
- R3: A transfer to bank 2 while `card_present` is 0 ends with an error response and no external access.
- R4: An error response lasts exactly two cycles: first `bus_err`=1 with `bus_ready`=0, then `bus_err`=1 with `bus_ready`=1. `mem_cs` is low in both cycles.
- R5: A 32-bit transfer makes two external accesses, each of `ACC_CYCLES` cycles. The first goes to the even half-word address and carries bits [15:0]. The second goes to the next address and carries bits [31:16]. Read halves are assembled in the same order, low half in bits [15:0].
- R6: On a byte-select bank, a byte write drives `mem_be_n`=2'b10 for an even byte offset and 2'b01 for an odd one, and changes only that byte. Half-word and word writes drive 2'b00.
- R7: On a byte-select bank, a byte or half-word read drives `mem_be_n`=2'b00, fetches the full 16-bit word, and returns the addressed data in its natural lanes with all other bus bits zero.
- R8: On a bank without byte select (0 or 3), a byte write ends with an error response, makes no external write, and leaves the memory contents unchanged.
- R9: On a bank without byte select, a byte read is allowed. It reads the whole 16-bit word with `mem_be_n`=2'b00 and returns the addressed byte as in R7.
- R10: `bus_ready` is low from the cycle after acceptance until the single completion cycle, and is low in every cycle where `mem_cs` is high. Each accepted transfer produces exactly one completion cycle.
- R11: After reset, `bus_ready`=1, `bus_err`=0 and `mem_cs`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request, taken when `bus_ready` is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = byte, 1 = half-word, 2 = word |
| req_addr | input | ADDR_W | Byte address; top BANK_W bits select the bank |
| req_wdata | input | 32 | Write data in natural lanes |
| bus_ready | output | 1 | High when idle or completing; low while busy |
| bus_err | output | 1 | Error response flag |
| bus_rdata | output | 32 | Read data, valid in the completion cycle |
| bank_en | input | 2**BANK_W | Per-bank enable |
| nor_acc_en | input | 1 | Access enable for the NOR bank |
| card_present | input | 1 | Card presence level for the card bank |
| mem_cs | output | 1 | External access strobe, active high |
| mem_we | output | 1 | External write when high during `mem_cs` |
| mem_bank | output | BANK_W | Bank of the current access |
| mem_addr | output | ADDR_W-BANK_W-1 | Half-word address in the bank |
| mem_be_n | output | 2 | Active-low byte-lane enables, bit 0 = bits [7:0] |
| mem_wdata | output | 16 | Write data to memory |
| mem_rdata | input | 16 | Read data from memory |

## Verification
The properties assume that `req_size` never carries the reserved value 3 and that word transfers have their two low address bits at zero. They also assume that the static configuration inputs change only while the block is idle. The stimulus meets these assumptions: every request is driven at a falling edge and removed after one accepting edge, and the next request waits until the previous completion has been seen. Configuration changes happen only between transfers, and word addresses are built from multiples of four.

// File: rtl/smw_pkg.sv
package smw_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_ACC  = 2'd1,
    S_ERR  = 2'd2,
    S_DONE = 2'd3
  } seq_state_e;

  // Active-low lane enables for a write on a byte-select device
  function automatic logic [1:0] write_be_n(xfer_size_e sz, logic odd);
    if (sz == SZ_BYTE) return odd ? 2'b01 : 2'b10;
    return 2'b00;
  endfunction

  // Half-word placed on the memory path for a given part of a transfer
  function automatic logic [15:0] write_half(logic [31:0] wd, xfer_size_e sz,
                                             logic [1:0] off, logic part);
    logic [7:0] b;
    case (off)
      2'd0:    b = wd[7:0];
      2'd1:    b = wd[15:8];
      2'd2:    b = wd[23:16];
      default: b = wd[31:24];
    endcase
    case (sz)
      SZ_WORD: return part ? wd[31:16] : wd[15:0];
      SZ_HALF: return off[1] ? wd[31:16] : wd[15:0];
      default: return {b, b};
    endcase
  endfunction

  // Read result in natural lanes, unused bytes zero
  function automatic logic [31:0] place_read(xfer_size_e sz, logic [1:0] off,
                                             logic [15:0] lo, logic [15:0] cur);
    logic [7:0] b;
    b = off[0] ? cur[15:8] : cur[7:0];
    case (sz)
      SZ_WORD: return {cur, lo};
      SZ_HALF: return off[1] ? {cur, 16'h0} : {16'h0, cur};
      default: return {24'h0, b} << {off, 3'b000};
    endcase
  endfunction

endpackage

// File: rtl/smw_decode.sv
module smw_decode
  import smw_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter logic [(1<<BANK_W)-1:0] NOBS_MASK = '0,
  parameter int NOR_BANK  = 0,
  parameter int CARD_BANK = 2
) (
  input  logic [BANK_W-1:0]        bank,
  input  logic                     write,
  input  xfer_size_e               size,
  input  logic [(1<<BANK_W)-1:0]   bank_en,
  input  logic                     nor_acc_en,
  input  logic                     card_present,
  output logic                     err_off,
  output logic                     err_nor,
  output logic                     err_card,
  output logic                     err_bytewr,
  output logic                     err_any
);
  always_comb begin
    err_off    = !bank_en[bank];
    err_nor    = (bank == BANK_W'(NOR_BANK)) && !nor_acc_en;
    err_card   = (bank == BANK_W'(CARD_BANK)) && !card_present;
    err_bytewr = NOBS_MASK[bank] && write && (size == SZ_BYTE);
    err_any    = err_off || err_nor || err_card || err_bytewr;
  end
endmodule

// File: rtl/smw_lanes.sv
module smw_lanes
  import smw_pkg::*;
(
  input  logic        active,
  input  logic        write,
  input  xfer_size_e  size,
  input  logic [1:0]  off,
  input  logic        part,
  input  logic [31:0] wdata,
  output logic [1:0]  be_n,
  output logic [15:0] wdata16
);
  always_comb begin
    if (!active)     be_n = 2'b11;
    else if (!write) be_n = 2'b00;
    else             be_n = write_be_n(size, off[0]);
    wdata16 = write_half(wdata, size, off, part);
  end
endmodule

// File: rtl/smw_seq.sv
module smw_seq
  import smw_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BANK_W     = 2,
  parameter int ACC_CYCLES = 2,
  localparam int MEM_AW = ADDR_W - BANK_W - 1,
  localparam int CW     = (ACC_CYCLES > 1) ? $clog2(ACC_CYCLES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              start_err,
  input  logic              req_write,
  input  xfer_size_e        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [15:0]       mem_rdata,
  output seq_state_e        state,
  output logic              part,
  output logic              acc_start,
  output logic              acc_last,
  output logic              q_write,
  output xfer_size_e        q_size,
  output logic [1:0]        q_off,
  output logic [31:0]       q_wdata,
  output logic [BANK_W-1:0] q_bank,
  output logic [MEM_AW-1:0] haddr,
  output logic              err_q,
  output logic [31:0]       rdata_q
);
  logic [CW-1:0]     cnt;
  logic [MEM_AW-1:0] q_haddr;
  logic [15:0]       lo_q;
  logic              more;

  assign acc_start = (state == S_ACC) && (cnt == '0);
  assign acc_last  = (state == S_ACC) && (cnt == CW'(ACC_CYCLES - 1));
  assign more      = (q_size == SZ_WORD) && !part;
  assign haddr     = {q_haddr[MEM_AW-1:1], q_haddr[0] | part};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      part    <= 1'b0;
      cnt     <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
      lo_q    <= '0;
      q_write <= 1'b0;
      q_size  <= SZ_BYTE;
      q_off   <= '0;
      q_wdata <= '0;
      q_bank  <= '0;
      q_haddr <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: begin
          if (accept) begin
            q_write <= req_write;
            q_size  <= req_size;
            q_off   <= req_addr[1:0];
            q_wdata <= req_wdata;
            q_bank  <= req_addr[ADDR_W-1 -: BANK_W];
            q_haddr <= (req_size == SZ_WORD) ?
                       {req_addr[ADDR_W-BANK_W-1:2], 1'b0} :
                       req_addr[ADDR_W-BANK_W-1:1];
            part    <= 1'b0;
            cnt     <= '0;
            state   <= start_err ? S_ERR : S_ACC;
          end else begin
            state <= S_IDLE;
          end
        end
        S_ERR: begin
          err_q <= 1'b1;
          state <= S_DONE;
        end
        default: begin
          if (acc_last) begin
            cnt <= '0;
            if (more) begin
              part <= 1'b1;
              lo_q <= mem_rdata;
            end else begin
              err_q   <= 1'b0;
              rdata_q <= q_write ? 32'h0 : place_read(q_size, q_off, lo_q, mem_rdata);
              state   <= S_DONE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/smem_width_adapter.sv
module smem_width_adapter
  import smw_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int BANK_W     = 2,
  parameter int ACC_CYCLES = 2,
  parameter logic [(1<<BANK_W)-1:0] NOBS_MASK = 4'b1001,
  parameter int NOR_BANK   = 0,
  parameter int CARD_BANK  = 2,
  localparam int NB     = 1 << BANK_W,
  localparam int MEM_AW = ADDR_W - BANK_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              bus_ready,
  output logic              bus_err,
  output logic [31:0]       bus_rdata,
  input  logic [NB-1:0]     bank_en,
  input  logic              nor_acc_en,
  input  logic              card_present,
  output logic              mem_cs,
  output logic              mem_we,
  output logic [BANK_W-1:0] mem_bank,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [1:0]        mem_be_n,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);
  seq_state_e  state;
  xfer_size_e  size_in, q_size;
  logic        accept, start_err;
  logic        err_off, err_nor, err_card, err_bytewr;
  logic        part_w, acc_start, acc_last;
  logic        q_write, err_q;
  logic [1:0]  q_off;
  logic [31:0] q_wdata, rdata_q;

  assign size_in = xfer_size_e'(req_size);
  assign accept  = req_valid && bus_ready;

  smw_decode #(
    .BANK_W(BANK_W), .NOBS_MASK(NOBS_MASK),
    .NOR_BANK(NOR_BANK), .CARD_BANK(CARD_BANK)
  ) u_dec (
    .bank(req_addr[ADDR_W-1 -: BANK_W]), .write(req_write), .size(size_in),
    .bank_en(bank_en), .nor_acc_en(nor_acc_en), .card_present(card_present),
    .err_off(err_off), .err_nor(err_nor), .err_card(err_card),
    .err_bytewr(err_bytewr), .err_any(start_err)
  );

  smw_seq #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .ACC_CYCLES(ACC_CYCLES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .start_err(start_err),
    .req_write(req_write), .req_size(size_in), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_rdata(mem_rdata),
    .state(state), .part(part_w), .acc_start(acc_start), .acc_last(acc_last),
    .q_write(q_write), .q_size(q_size), .q_off(q_off), .q_wdata(q_wdata),
    .q_bank(mem_bank), .haddr(mem_addr), .err_q(err_q), .rdata_q(rdata_q)
  );

  smw_lanes u_lanes (
    .active(mem_cs), .write(q_write), .size(q_size), .off(q_off),
    .part(part_w), .wdata(q_wdata), .be_n(mem_be_n), .wdata16(mem_wdata)
  );

  assign mem_cs    = (state == S_ACC);
  assign mem_we    = mem_cs && q_write;
  assign bus_ready = (state == S_IDLE) || (state == S_DONE);
  assign bus_err   = (state == S_ERR) || ((state == S_DONE) && err_q);
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/smw_checker.sv
module smw_checker #(
  parameter int BANK_W = 2,
  parameter logic [(1<<BANK_W)-1:0] NOBS_MASK = '0,
  parameter int MEM_AW = 21
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_ready,
  input logic              bus_err,
  input logic              mem_cs,
  input logic              mem_we,
  input logic [BANK_W-1:0] mem_bank,
  input logic [MEM_AW-1:0] mem_addr,
  input logic [1:0]        mem_be_n,
  input logic              acc_start,
  input logic              acc_part
);
  a_r1_no_strobe_in_error: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> !mem_cs);

  a_r4_error_two_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !bus_ready) |=> (bus_err && bus_ready));

  a_r10_busy_while_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cs |-> !bus_ready);

  a_r5_upper_half_next: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && acc_part) |-> (mem_addr == $past(mem_addr) + 1'b1));

  a_r7_read_full_word: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs && !mem_we) |-> (mem_be_n == 2'b00));

  a_r6_write_lane_used: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs && mem_we) |-> (mem_be_n != 2'b11));

  a_r8_no_partial_on_nobs: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs && mem_we && NOBS_MASK[mem_bank]) |-> (mem_be_n == 2'b00));

  a_r11_idle_lanes_off: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs |-> (mem_be_n == 2'b11));
endmodule

bind smem_width_adapter smw_checker #(
  .BANK_W(BANK_W), .NOBS_MASK(NOBS_MASK), .MEM_AW(MEM_AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .bus_err(bus_err),
  .mem_cs(mem_cs), .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr),
  .mem_be_n(mem_be_n), .acc_start(acc_start), .acc_part(part_w)
);

// File: tb/sim_smem_width_adapter.sv
`timescale 1ns/1ps
module sim_smem_width_adapter;
  localparam int ADDR_W = 24;
  localparam int BANK_W = 2;
  localparam int ACC    = 2;
  localparam int MAW    = ADDR_W - BANK_W - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]        req_size = 2'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              bus_ready, bus_err;
  logic [31:0]       bus_rdata;
  logic [3:0]        bank_en = 4'b1111;
  logic              nor_acc_en = 1'b1, card_present = 1'b1;
  logic              mem_cs, mem_we;
  logic [BANK_W-1:0] mem_bank;
  logic [MAW-1:0]    mem_addr;
  logic [1:0]        mem_be_n;
  logic [15:0]       mem_wdata, mem_rdata;

  smem_width_adapter u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .bank_en(bank_en), .nor_acc_en(nor_acc_en), .card_present(card_present),
    .mem_cs(mem_cs), .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr),
    .mem_be_n(mem_be_n), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // memory model and bench-side shadow copy
  logic [15:0] mem_arr [256];
  logic [15:0] shadow  [256];
  assign mem_rdata = mem_arr[{mem_bank, mem_addr[5:0]}];
  always @(posedge clk) begin
    if (mem_cs && mem_we) begin
      if (!mem_be_n[0]) mem_arr[{mem_bank, mem_addr[5:0]}][7:0]  <= mem_wdata[7:0];
      if (!mem_be_n[1]) mem_arr[{mem_bank, mem_addr[5:0]}][15:8] <= mem_wdata[15:8];
    end
  end

  typedef struct {
    string       tag;
    logic        err;
    logic        write;
    logic [31:0] rdata;
    int          cs_cycles;
    logic [1:0]  be_n;
  } exp_t;
  exp_t sb[$];

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  task automatic check(string req, logic ok, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ix(logic [1:0] b, int hw);
    return {b, hw[5:0]};
  endfunction

  // driver: computes expectation, pushes it, issues the request
  task automatic xfer(string tag, logic wr, logic [1:0] sz, logic [1:0] bank,
                      int baddr, logic [31:0] wd);
    exp_t e;
    int hw, off;
    logic [15:0] h;
    logic [7:0] b;
    hw = baddr >> 1;
    off = baddr & 3;
    e.tag = tag; e.write = wr; e.rdata = 32'h0;
    e.err = !bank_en[bank] || (bank == 2'd0 && !nor_acc_en) ||
            (bank == 2'd2 && !card_present) ||
            ((bank == 2'd0 || bank == 2'd3) && wr && sz == 2'd0);
    e.cs_cycles = e.err ? 0 : ((sz == 2'd2) ? 2 * ACC : ACC);
    e.be_n = 2'b00;
    if (!e.err && wr && sz == 2'd0) e.be_n = (off % 2 == 1) ? 2'b01 : 2'b10;
    if (!e.err) begin
      if (wr) begin
        case (sz)
          2'd2: begin
            shadow[ix(bank, hw)]     = wd[15:0];
            shadow[ix(bank, hw + 1)] = wd[31:16];
          end
          2'd1: shadow[ix(bank, hw)] = (off >= 2) ? wd[31:16] : wd[15:0];
          default: begin
            b = wd[8*off +: 8];
            if (off % 2 == 1) shadow[ix(bank, hw)][15:8] = b;
            else              shadow[ix(bank, hw)][7:0]  = b;
          end
        endcase
      end else begin
        h = shadow[ix(bank, hw)];
        case (sz)
          2'd2: e.rdata = {shadow[ix(bank, hw + 1)], h};
          2'd1: e.rdata = (off >= 2) ? {h, 16'h0} : {16'h0, h};
          default: begin
            b = (off % 2 == 1) ? h[15:8] : h[7:0];
            e.rdata = 32'(b) << (8 * off);
          end
        endcase
      end
    end
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr  = {bank, 22'(baddr)}; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    wait (sb.size() == 0);
  endtask

  // monitor
  int cs_cnt = 0, err_cnt = 0;
  logic [1:0] last_be = 2'b11;
  logic prev_ready = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      if (mem_cs) begin cs_cnt++; last_be = mem_be_n; end
      if (bus_err) err_cnt++;
      if (mem_cs) check("R10 ready low during access", !bus_ready, 32'(bus_ready), 32'd0);
      if (bus_ready && !prev_ready && sb.size() > 0) begin
        e = sb.pop_front();
        check({"R1/R2/R3/R8 err ", e.tag}, bus_err == e.err, 32'(bus_err), 32'(e.err));
        check({"R10/R5 access cycles ", e.tag}, cs_cnt == e.cs_cycles,
              32'(cs_cnt), 32'(e.cs_cycles));
        if (e.err)
          check({"R4 error cycles ", e.tag}, err_cnt == 2, 32'(err_cnt), 32'd2);
        else begin
          check({"R6/R7/R9 lanes ", e.tag}, last_be == e.be_n, 32'(last_be), 32'(e.be_n));
          if (!e.write)
            check({"R5/R7/R9 rdata ", e.tag}, bus_rdata == e.rdata, bus_rdata, e.rdata);
        end
        cs_cnt = 0; err_cnt = 0;
      end
      prev_ready = bus_ready;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_arr[i] = 16'(16'hA000 ^ (i * 16'h0137));
      shadow[i]  = 16'(16'hA000 ^ (i * 16'h0137));
    end
    repeat (3) @(negedge clk);
    check("R11 reset ready", bus_ready == 1'b1, 32'(bus_ready), 32'd1);
    check("R11 reset err",   bus_err == 1'b0,   32'(bus_err),   32'd0);
    check("R11 reset cs",    mem_cs == 1'b0,    32'(mem_cs),    32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: split word on SRAM bank
    xfer("r5_wr", 1, 2'd2, 2'd1, 16, 32'h1122_3344);
    xfer("r5_rd", 0, 2'd2, 2'd1, 16, 32'h0);
    xfer("r5_rd_init", 0, 2'd2, 2'd1, 40, 32'h0);
    // R6: byte writes in each lane, then word read back
    for (int k = 0; k < 4; k++)
      xfer("r6_bwr", 1, 2'd0, 2'd1, 24 + k, 32'(8'h5A + k) << (8 * k));
    xfer("r6_rd", 0, 2'd2, 2'd1, 24, 32'h0);
    xfer("r6_hwr", 1, 2'd1, 2'd1, 34, 32'hBEEF_0000);
    // R7: narrow reads on SRAM and card bank
    xfer("r7_hrd", 0, 2'd1, 2'd1, 34, 32'h0);
    xfer("r7_hrd0", 0, 2'd1, 2'd1, 32, 32'h0);
    for (int k = 0; k < 4; k++) xfer("r7_brd", 0, 2'd0, 2'd2, 8 + k, 32'h0);
    // R9: byte reads on banks without byte select
    for (int k = 0; k < 4; k++) xfer("r9_brd", 0, 2'd0, 2'd0, 4 + k, 32'h0);
    xfer("r9_brd3", 0, 2'd0, 2'd3, 13, 32'h0);
    // R8: byte writes refused, memory unchanged
    xfer("r8_bwr0", 1, 2'd0, 2'd0, 5, 32'h0000_FF00);
    xfer("r8_chk0", 0, 2'd2, 2'd0, 4, 32'h0);
    xfer("r8_bwr3", 1, 2'd0, 2'd3, 12, 32'h0000_00FF);
    xfer("r8_chk3", 0, 2'd1, 2'd3, 12, 32'h0);
    xfer("r8_hwr3", 1, 2'd1, 2'd3, 12, 32'h0000_C0DE);
    xfer("r8_hrd3", 0, 2'd1, 2'd3, 12, 32'h0);
    // R1: disabled bank
    @(negedge clk); bank_en = 4'b1101;
    xfer("r1_wr", 1, 2'd2, 2'd1, 16, 32'hDEAD_BEEF);
    xfer("r1_rd", 0, 2'd0, 2'd1, 17, 32'h0);
    @(negedge clk); bank_en = 4'b1111;
    xfer("r1_after", 0, 2'd2, 2'd1, 16, 32'h0);
    // R2: NOR access enable
    @(negedge clk); nor_acc_en = 1'b0;
    xfer("r2_rd", 0, 2'd1, 2'd0, 2, 32'h0);
    xfer("r2_other_bank", 0, 2'd1, 2'd3, 2, 32'h0);
    @(negedge clk); nor_acc_en = 1'b1;
    xfer("r2_after", 0, 2'd1, 2'd0, 2, 32'h0);
    // R3: card presence
    @(negedge clk); card_present = 1'b0;
    xfer("r3_wr", 1, 2'd1, 2'd2, 20, 32'h0000_7777);
    @(negedge clk); card_present = 1'b1;
    xfer("r3_chk", 0, 2'd1, 2'd2, 20, 32'h0);
    xfer("r3_wr_ok", 1, 2'd2, 2'd2, 20, 32'hCAFE_F00D);
    xfer("r3_rd_ok", 0, 2'd2, 2'd2, 20, 32'h0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule